// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks the cache misses that are waiting on memory, so the cache can keep serving other requests while they are outstanding. Each miss that arrives is compared against the block address of every in-use entry in the same cycle. If no entry matches, the miss is primary. It takes the lowest-numbered free entry, and one fill request goes out to the next level of memory. If an entry already tracks the same block, the miss is secondary. Its target record is appended to that entry and no new request goes out.

A target record holds only what the requester needs when the data comes back: the word offset inside the block and a destination tag. Offsets are stored explicitly, so several misses to the same word can share an entry. When the fill for an entry is returned by its entry number, the entry's targets are replayed one per cycle in the order they arrived. The entry frees itself on the cycle its last target goes out. A miss to a block that is being filled or replayed joins the replay after the targets already held. When several entries have data ready, the lowest-numbered one is replayed first, and a replay that has begun runs to its end. The stall output is combinational. It tells the requester that the miss now on the inputs cannot be taken.

Top module: `mshr_file`

## Requirements
- R1: After synchronous reset every entry is free, and req_valid and resp_valid are low.
- R2: An accepted miss whose block matches no in-use entry causes exactly one req_valid pulse in the cycle after the miss is sampled. The pulse carries the miss block on req_blk and, on req_id, the lowest-numbered free entry.
- R3: A miss whose block matches an in-use entry is accepted with stall low while that entry has a free target slot, and it produces no request. This holds even when every entry is in use.
- R4: Several misses to the same word of a pending block are all accepted, and each is replayed with its own tag.
- R5: While all ENTRIES entries are in use, a miss to an unmatched block sees stall high in the same cycle. It is not recorded and never produces a request.
- R6: An entry holds at most TARGETS targets. A matching miss that arrives when the entry is full sees stall high and is dropped: the replay has exactly TARGETS responses.
- R7: When fill_valid with fill_id is sampled at clock edge E, the entry's targets appear on resp_valid/resp_blk/resp_word/resp_tag one per cycle. They start in the cycle after edge E+1, follow one another in consecutive cycles, and keep arrival order.
- R8: An entry is freed on the edge that outputs its last target. After that, a miss to the same block is primary again.
- R9: A miss to a block whose fill is sampled in the same cycle, or whose targets are being replayed, is merged without a request. It is replayed after the targets held before it, with no gap. This includes a miss sampled on the edge of what would have been the last target.
- R10: Once an entry's replay starts, all of its targets are output before any other entry's. Among entries waiting with data, the lowest-numbered goes next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_blk | input | BLK_W | Block address of the miss |
| miss_word | input | WORD_W | Word offset inside the block |
| miss_tag | input | TAG_W | Destination tag of the requester |
| stall | output | 1 | The presented miss cannot be accepted (combinational) |
| req_valid | output | 1 | One-cycle fill request to the next memory level |
| req_blk | output | BLK_W | Block address of the fill request |
| req_id | output | ID_W | Entry number the fill must be returned with |
| fill_valid | input | 1 | Fill data for an entry has returned |
| fill_id | input | ID_W | Entry number of the returning fill |
| resp_valid | output | 1 | A replayed target is presented |
| resp_blk | output | BLK_W | Block address of the replayed target |
| resp_word | output | WORD_W | Word offset of the replayed target |
| resp_tag | output | TAG_W | Destination tag of the replayed target |

## Verification
Stall is combinational and is read 1 ns after the inputs are driven, in the same cycle as the miss. A request is due one edge after its miss is sampled, and the first replayed target is due two edges after the fill is sampled. Each further target follows one edge after the one before it. A monitor stamps every request and response with the number of the clock edge it followed, 1 ns after that edge. The checks compare these stamps against edge numbers taken when the stimulus was driven, so a response that is late, early or separated by a gap is reported, not just a wrong value.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    parameter int ENTRIES = 4;
    parameter int TARGETS = 4;
    parameter int BLK_W   = 26;
    parameter int WORD_W  = 4;
    parameter int TAG_W   = 6;

    localparam int ID_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(TARGETS + 1);
    localparam int PTR_W = (TARGETS > 1) ? $clog2(TARGETS) : 1;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [ID_W-1:0]  id_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [TAG_W-1:0]  tag;
    } target_t;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } ent_state_e;

    function automatic id_t lowest_set(input logic [ENTRIES-1:0] v);
        id_t r;
        r = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = id_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
    import mshr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alloc,
    input  logic    merge,
    input  logic    fill,
    input  logic    pop,
    input  blk_t    lk_blk,
    input  target_t tgt_in,
    output logic    busy,
    output logic    ready,
    output logic    hit,
    output logic    full,
    output target_t head,
    output blk_t    blk_q
);
    ent_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] rd;
    target_t          slots [TARGETS];
    logic             last;

    assign busy  = (state != ST_FREE);
    assign ready = (state == ST_READY);
    assign hit   = busy && (blk_q == lk_blk);
    assign full  = (cnt == CNT_W'(TARGETS));
    assign head  = slots[rd];
    assign last  = (CNT_W'(rd) + CNT_W'(1)) == cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FREE;
            cnt   <= '0;
            rd    <= '0;
        end else if (alloc) begin
            state    <= ST_WAIT;
            blk_q    <= lk_blk;
            slots[0] <= tgt_in;
            cnt      <= CNT_W'(1);
            rd       <= '0;
        end else begin
            if (merge) begin
                slots[PTR_W'(cnt)] <= tgt_in;
            end
            cnt <= cnt + CNT_W'(merge);
            if (fill && state == ST_WAIT) begin
                state <= ST_READY;
            end
            if (pop) begin
                rd <= rd + PTR_W'(1);
                if (last && !merge) begin
                    state <= ST_FREE;
                end
            end
        end
    end

    assert_merge_has_room_R6: assert property (@(posedge clk) disable iff (rst)
        merge |-> !full);

    assert_alloc_only_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (state == ST_FREE));

    assert_pop_only_ready_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> (state == ST_READY));
endmodule

// File: rtl/mshr_alloc.sv
module mshr_alloc
    import mshr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    input  blk_t               miss_blk,
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [ENTRIES-1:0] full_vec,
    input  logic [ENTRIES-1:0] busy_vec,
    output logic               stall,
    output logic [ENTRIES-1:0] alloc_vec,
    output logic [ENTRIES-1:0] merge_vec,
    output logic               req_valid,
    output blk_t               req_blk,
    output id_t                req_id
);
    logic hit_any;
    logic hit_full;
    logic has_free;
    logic accept;
    id_t  free_id;

    assign hit_any  = |hit_vec;
    assign hit_full = |(hit_vec & full_vec);
    assign has_free = |(~busy_vec);
    assign free_id  = lowest_set(~busy_vec);

    assign stall  = miss_valid && (hit_any ? hit_full : !has_free);
    assign accept = miss_valid && !stall;

    assign merge_vec = (accept && hit_any) ? hit_vec : '0;
    assign alloc_vec = (accept && !hit_any) ? (ENTRIES'(1) << free_id) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_blk   <= '0;
            req_id    <= '0;
        end else begin
            req_valid <= accept && !hit_any;
            req_blk   <= miss_blk;
            req_id    <= free_id;
        end
    end

    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && (hit_vec == '0) && (&busy_vec)) |-> stall);
endmodule

// File: rtl/mshr_replay.sv
module mshr_replay
    import mshr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ENTRIES-1:0]    ready_vec,
    input  target_t [ENTRIES-1:0] head_arr,
    input  blk_t [ENTRIES-1:0]    blk_arr,
    output logic [ENTRIES-1:0]    pop_vec,
    output logic                  resp_valid,
    output blk_t                  resp_blk,
    output logic [WORD_W-1:0]     resp_word,
    output logic [TAG_W-1:0]      resp_tag
);
    logic any_ready;
    logic draining;
    id_t  cur;
    id_t  sel;

    assign any_ready = |ready_vec;
    assign sel       = (draining && ready_vec[cur]) ? cur : lowest_set(ready_vec);
    assign pop_vec   = any_ready ? (ENTRIES'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            draining   <= 1'b0;
            cur        <= '0;
            resp_valid <= 1'b0;
            resp_blk   <= '0;
            resp_word  <= '0;
            resp_tag   <= '0;
        end else begin
            draining   <= any_ready;
            cur        <= sel;
            resp_valid <= any_ready;
            resp_blk   <= blk_arr[sel];
            resp_word  <= head_arr[sel].word;
            resp_tag   <= head_arr[sel].tag;
        end
    end

    assert_one_pop_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop_vec));

    assert_pop_is_ready_R7: assert property (@(posedge clk) disable iff (rst)
        ((pop_vec & ~ready_vec) == '0));
endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [BLK_W-1:0]  miss_blk,
    input  logic [WORD_W-1:0] miss_word,
    input  logic [TAG_W-1:0]  miss_tag,
    output logic              stall,
    output logic              req_valid,
    output logic [BLK_W-1:0]  req_blk,
    output logic [ID_W-1:0]   req_id,
    input  logic              fill_valid,
    input  logic [ID_W-1:0]   fill_id,
    output logic              resp_valid,
    output logic [BLK_W-1:0]  resp_blk,
    output logic [WORD_W-1:0] resp_word,
    output logic [TAG_W-1:0]  resp_tag
);
    logic [ENTRIES-1:0]    hit_vec;
    logic [ENTRIES-1:0]    full_vec;
    logic [ENTRIES-1:0]    busy_vec;
    logic [ENTRIES-1:0]    ready_vec;
    logic [ENTRIES-1:0]    alloc_vec;
    logic [ENTRIES-1:0]    merge_vec;
    logic [ENTRIES-1:0]    pop_vec;
    target_t [ENTRIES-1:0] head_arr;
    blk_t [ENTRIES-1:0]    blk_arr;
    target_t               miss_tgt;

    assign miss_tgt = '{word: miss_word, tag: miss_tag};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        mshr_entry u_ent (
            .clk    (clk),
            .rst    (rst),
            .alloc  (alloc_vec[g]),
            .merge  (merge_vec[g]),
            .fill   (fill_valid && (fill_id == ID_W'(g))),
            .pop    (pop_vec[g]),
            .lk_blk (miss_blk),
            .tgt_in (miss_tgt),
            .busy   (busy_vec[g]),
            .ready  (ready_vec[g]),
            .hit    (hit_vec[g]),
            .full   (full_vec[g]),
            .head   (head_arr[g]),
            .blk_q  (blk_arr[g])
        );
    end

    mshr_alloc u_alloc (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_blk   (miss_blk),
        .hit_vec    (hit_vec),
        .full_vec   (full_vec),
        .busy_vec   (busy_vec),
        .stall      (stall),
        .alloc_vec  (alloc_vec),
        .merge_vec  (merge_vec),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .req_id     (req_id)
    );

    mshr_replay u_replay (
        .clk        (clk),
        .rst        (rst),
        .ready_vec  (ready_vec),
        .head_arr   (head_arr),
        .blk_arr    (blk_arr),
        .pop_vec    (pop_vec),
        .resp_valid (resp_valid),
        .resp_blk   (resp_blk),
        .resp_word  (resp_word),
        .resp_tag   (resp_tag)
    );

    assert_req_not_merged_R3: assert property (@(posedge clk) disable iff (rst)
        (|merge_vec) |=> !req_valid);
endmodule

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;
    import mshr_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              miss_valid;
    logic [BLK_W-1:0]  miss_blk;
    logic [WORD_W-1:0] miss_word;
    logic [TAG_W-1:0]  miss_tag;
    logic              stall;
    logic              req_valid;
    logic [BLK_W-1:0]  req_blk;
    logic [ID_W-1:0]   req_id;
    logic              fill_valid;
    logic [ID_W-1:0]   fill_id;
    logic              resp_valid;
    logic [BLK_W-1:0]  resp_blk;
    logic [WORD_W-1:0] resp_word;
    logic [TAG_W-1:0]  resp_tag;

    always #2 clk = ~clk;

    mshr_file i_mshr_file (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_word(miss_word), .miss_tag(miss_tag),
        .stall(stall),
        .req_valid(req_valid), .req_blk(req_blk), .req_id(req_id),
        .fill_valid(fill_valid), .fill_id(fill_id),
        .resp_valid(resp_valid), .resp_blk(resp_blk), .resp_word(resp_word), .resp_tag(resp_tag)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int qn = 0;
    longint qblk, qid, qcyc;
    int rn = 0;
    longint rblk [256];
    longint rword [256];
    longint rtag [256];
    longint rcyc [256];

    always @(posedge clk) begin
        #1;
        cyc++;
        if (req_valid === 1'b1) begin
            qn++;
            qblk = longint'(req_blk);
            qid  = longint'(req_id);
            qcyc = cyc;
        end
        if (resp_valid === 1'b1 && rn < 256) begin
            rblk[rn]  = longint'(resp_blk);
            rword[rn] = longint'(resp_word);
            rtag[rn]  = longint'(resp_tag);
            rcyc[rn]  = cyc;
            rn++;
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic put_miss(input longint b, input longint w, input longint t, output logic st);
        miss_valid = 1'b1;
        miss_blk   = BLK_W'(b);
        miss_word  = WORD_W'(w);
        miss_tag   = TAG_W'(t);
        #1 st = stall;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic put_fill(input longint id);
        fill_valid = 1'b1;
        fill_id    = ID_W'(id);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_resp(input string what, input int i, input longint b,
                            input longint w, input longint t, input longint c);
        chk({what, " blk"}, rblk[i], b);
        chk({what, " word"}, rword[i], w);
        chk({what, " tag"}, rtag[i], t);
        chk({what, " cycle"}, rcyc[i], c);
    endtask

    task automatic t_reset;
        chk("R1 req_valid after reset", longint'(req_valid), 0);
        chk("R1 resp_valid after reset", longint'(resp_valid), 0);
        chk("R1 no request logged", qn, 0);
    endtask

    task automatic t_primary_secondary;
        logic st;
        int c0, q0, r0;
        q0 = qn;
        c0 = cyc;
        put_miss(64'h100, 3, 1, st);
        chk("R2 primary stall", longint'(st), 0);
        chk("R2 one request", qn, q0 + 1);
        chk("R2 request blk", qblk, 64'h100);
        chk("R2 request entry", qid, 0);
        chk("R2 request cycle", qcyc, c0 + 1);
        put_miss(64'h100, 5, 2, st);
        chk("R3 secondary stall", longint'(st), 0);
        put_miss(64'h100, 3, 3, st);
        chk("R4 same word stall", longint'(st), 0);
        idle(2);
        chk("R3 no extra request", qn, q0 + 1);
        r0 = rn;
        c0 = cyc;
        put_fill(0);
        idle(5);
        chk("R7 response count", rn, r0 + 3);
        chk_resp("R7 first", r0, 64'h100, 3, 1, c0 + 2);
        chk_resp("R7 second", r0 + 1, 64'h100, 5, 2, c0 + 3);
        chk_resp("R4 third same word", r0 + 2, 64'h100, 3, 3, c0 + 4);
        put_miss(64'h100, 0, 4, st);
        chk("R8 reprimary stall", longint'(st), 0);
        chk("R8 new request after free", qn, q0 + 2);
        chk("R8 entry reused", qid, 0);
        put_fill(0);
        idle(3);
        chk("R8 single replay", rn, r0 + 4);
    endtask

    task automatic t_all_entries;
        logic st;
        int c0, q0, r0;
        q0 = qn;
        for (int i = 0; i < 4; i++) begin
            put_miss(64'h200 + i, i, 8 + i, st);
            chk("R2 fill entry stall", longint'(st), 0);
            chk("R2 lowest free entry", qid, i);
        end
        put_miss(64'h202, 7, 12, st);
        chk("R3 merge entry2 stall", longint'(st), 0);
        put_miss(64'h204, 0, 13, st);
        chk("R5 primary when full stalls", longint'(st), 1);
        put_miss(64'h201, 6, 14, st);
        chk("R3 merge while all busy", longint'(st), 0);
        idle(2);
        chk("R5 dropped miss no request", qn, q0 + 4);
        r0 = rn;
        c0 = cyc;
        put_fill(2);
        put_fill(0);
        put_fill(1);
        put_fill(3);
        idle(6);
        chk("R10 response count", rn, r0 + 6);
        chk_resp("R10 e2 t0", r0, 64'h202, 2, 10, c0 + 2);
        chk_resp("R10 e2 t1", r0 + 1, 64'h202, 7, 12, c0 + 3);
        chk_resp("R10 e0", r0 + 2, 64'h200, 0, 8, c0 + 4);
        chk_resp("R10 e1 t0", r0 + 3, 64'h201, 1, 9, c0 + 5);
        chk_resp("R10 e1 t1", r0 + 4, 64'h201, 6, 14, c0 + 6);
        chk_resp("R10 e3", r0 + 5, 64'h203, 3, 11, c0 + 7);
        put_miss(64'h204, 0, 15, st);
        chk("R5 dropped block is primary later", qn, q0 + 5);
        put_fill(qid);
        idle(3);
        chk("R5 dropped miss not replayed", rn, r0 + 7);
        chk("R5 replay tag", rtag[r0 + 6], 15);
    endtask

    task automatic t_target_full;
        logic st;
        int r0;
        longint id;
        for (int i = 0; i < 4; i++) begin
            put_miss(64'h300, i, 20 + i, st);
            chk("R6 slot accept", longint'(st), 0);
        end
        id = qid;
        put_miss(64'h300, 9, 30, st);
        chk("R6 full entry stalls", longint'(st), 1);
        r0 = rn;
        put_fill(id);
        idle(7);
        chk("R6 exactly TARGETS replays", rn, r0 + 4);
        for (int i = 0; i < 4; i++) begin
            chk("R6 replay order tag", rtag[r0 + i], 20 + i);
        end
    endtask

    task automatic t_collision;
        logic st;
        int c0, q0, r0;
        longint id;
        put_miss(64'h400, 1, 40, st);
        put_miss(64'h400, 2, 41, st);
        id = qid;
        q0 = qn;
        r0 = rn;
        c0 = cyc;
        fill_valid = 1'b1;
        fill_id    = ID_W'(id);
        miss_valid = 1'b1;
        miss_blk   = BLK_W'(64'h400);
        miss_word  = WORD_W'(3);
        miss_tag   = TAG_W'(42);
        #1 st = stall;
        @(negedge clk);
        fill_valid = 1'b0;
        miss_valid = 1'b0;
        chk("R9 same-cycle miss stall", longint'(st), 0);
        idle(2);
        put_miss(64'h400, 4, 43, st);
        chk("R9 miss on last pop stall", longint'(st), 0);
        idle(4);
        chk("R9 no request for merges", qn, q0);
        chk("R9 response count", rn, r0 + 4);
        chk_resp("R9 t0", r0, 64'h400, 1, 40, c0 + 2);
        chk_resp("R9 t1", r0 + 1, 64'h400, 2, 41, c0 + 3);
        chk_resp("R9 same-cycle target", r0 + 2, 64'h400, 3, 42, c0 + 4);
        chk_resp("R9 last-pop target", r0 + 3, 64'h400, 4, 43, c0 + 5);
        put_miss(64'h400, 0, 44, st);
        chk("R8 freed after extended replay", qn, q0 + 1);
        put_fill(qid);
        idle(3);
    endtask

    initial begin
        rst        = 1'b1;
        miss_valid = 1'b0;
        miss_blk   = '0;
        miss_word  = '0;
        miss_tag   = '0;
        fill_valid = 1'b0;
        fill_id    = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fork
            begin
                t_reset;
                t_primary_secondary;
                t_all_entries;
                t_target_full;
                t_collision;
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule